// File: doc/BRIEF.md
# Expansion Card Auto-Configuration Responder

This block is the card-side logic of a plug-and-play expansion bus. Cards sit on an enable chain in slot order. A card whose chain input is high and which has not yet been configured answers at one fixed configuration window. There it returns read-only identification bytes: a product code, plus a byte that holds the requested region size and a memory/IO flag. The host reads these bytes, chooses a free base address for the card, and writes that base into the card.

Once a base is written, the card stops answering at the window. It raises its chain output so the next card in the chain can appear at the window. From then on it asserts a registered select for accesses inside its assigned region. The host can instead write a shut-up register. That also marks the card configured and passes the chain on, but the card never decodes any address. The bus is a simple synchronous one: address, read and write strobes, and a byte of data.

Top module: `xcfg_card`

## Requirements
- R1: Synchronous active-high reset clears the configured state. During and after reset, chain_out, sel and cfg_hit are 0 and rdata is 0.
- R2: A read with chain_in high, on an unconfigured card, at window offset 0 returns the PRODUCT parameter on rdata with cfg_hit high, in the cycle after the read.
- R3: Window offset 1 reads back {IS_IO in bit 7, zeros in bits 6:3, SIZE_CODE in bits 2:0}. Region size is 64 KiB << SIZE_CODE. Reads at any other offset give cfg_hit high with rdata 0. Writes to offsets 0 and 1 change nothing. Outside a configuration read, rdata is 0 and cfg_hit is 0.
- R4: While chain_in is low, the card ignores the window. Reads give cfg_hit 0, and writes to offsets 2 and 3 leave chain_out at 0.
- R5: A write (wr high, rd low) to window offset 2 latches wdata as address bits 23:16 of the base. chain_out is high in the cycle after that write.
- R6: After configuration the window is ignored. Reads give cfg_hit 0, and a second base write leaves the decoded region unchanged.
- R7: Once configured through offset 2, sel is high in the cycle after a read or write whose address lies in [base, base + size − 1], and low otherwise.
- R8: A write to window offset 3 raises chain_out in the next cycle, and sel then never asserts for any address.
- R9: Before configuration, sel is never asserted.
- R10: Once high, chain_out stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Bus address |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered identification read data |
| cfg_hit | output | 1 | Registered: card answered a configuration read |
| sel | output | 1 | Registered: access fell in the assigned region |
| chain_in | input | 1 | Enable from the previous slot |
| chain_out | output | 1 | Enable to the next slot, high once configured |

## Verification
The hardest situations to reach are the ones after configuration, where every stimulus of interest is one that must now be ignored. These include window reads, a second base write, and addresses exactly one below and one above the assigned region. The stimulus first walks the card through unconfigured reads with the chain both low and high. It then configures the card with a directed base write and hits the four region boundaries directly. After that it floods a band of addresses around the region with seeded random accesses. A second reset followed by a shut-up write repeats the random flood, with select expected low throughout.

// File: rtl/xcfg_pkg.sv
package xcfg_pkg;
  typedef enum logic [1:0] {
    REG_PROD = 2'd0,
    REG_SIZE = 2'd1,
    REG_BASE = 2'd2,
    REG_SHUT = 2'd3
  } reg_idx_e;

  function automatic logic [7:0] size_byte(input logic io, input logic [2:0] code);
    return {io, 4'b0000, code};
  endfunction
endpackage

// File: rtl/xcfg_id_regs.sv
module xcfg_id_regs #(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] PRODUCT = 8'hA7,
  parameter logic [2:0] SIZE_CODE = 3'd2,
  parameter bit IS_IO = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_rd,
  input  logic              idx_ok,
  input  logic [1:0]        idx,
  output logic [DATA_W-1:0] rdata,
  output logic              cfg_hit
);
  import xcfg_pkg::*;

  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    if (idx_ok) begin
      unique case (reg_idx_e'(idx))
        REG_PROD: rd_mux = PRODUCT;
        REG_SIZE: rd_mux = DATA_W'(size_byte(IS_IO, SIZE_CODE));
        default:  rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata   <= '0;
      cfg_hit <= 1'b0;
    end else begin
      cfg_hit <= cfg_rd;
      rdata   <= cfg_rd ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/xcfg_state.sv
module xcfg_state #(
  parameter int BHW = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cfg_wr,
  input  logic [1:0]     idx,
  input  logic [BHW-1:0] wbase,
  output logic           cfgd,
  output logic           dec_en,
  output logic [BHW-1:0] base_hi
);
  import xcfg_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfgd    <= 1'b0;
      dec_en  <= 1'b0;
      base_hi <= '0;
    end else if (cfg_wr) begin
      if (reg_idx_e'(idx) == REG_BASE) begin
        base_hi <= wbase;
        dec_en  <= 1'b1;
        cfgd    <= 1'b1;
      end else if (reg_idx_e'(idx) == REG_SHUT) begin
        cfgd    <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/xcfg_decode.sv
module xcfg_decode #(
  parameter int ADDR_W   = 24,
  parameter int MIN_LOG2 = 16,
  parameter int SZ_LOG   = 18,
  localparam int BHW = ADDR_W - MIN_LOG2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dec_en,
  input  logic [BHW-1:0]    base_hi,
  input  logic [ADDR_W-1:0] addr,
  input  logic              acc,
  output logic              sel
);
  logic [ADDR_W:0] lo, hi, a_ext;
  logic            in_rng;

  always_comb begin
    lo     = {1'b0, base_hi, {MIN_LOG2{1'b0}}};
    hi     = lo + ((ADDR_W+1)'(1) << SZ_LOG);
    a_ext  = {1'b0, addr};
    in_rng = (a_ext >= lo) && (a_ext < hi);
  end

  always_ff @(posedge clk) begin
    if (rst) sel <= 1'b0;
    else     sel <= dec_en && acc && in_rng;
  end
endmodule

// File: rtl/xcfg_card.sv
module xcfg_card #(
  parameter int ADDR_W   = 24,
  parameter int DATA_W   = 8,
  parameter int WIN_W    = 8,
  parameter int MIN_LOG2 = 16,
  parameter logic [ADDR_W-1:0] CFG_BASE = 24'hE80000,
  parameter logic [DATA_W-1:0] PRODUCT  = 8'hA7,
  parameter logic [2:0] SIZE_CODE = 3'd2,
  parameter bit IS_IO = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              cfg_hit,
  output logic              sel,
  input  logic              chain_in,
  output logic              chain_out
);
  localparam int BHW    = ADDR_W - MIN_LOG2;
  localparam int SZ_LOG = MIN_LOG2 + int'(SIZE_CODE);

  logic           in_win, idx_ok, active, cfg_rd, cfg_wr;
  logic           cfgd, dec_en;
  logic [1:0]     idx;
  logic [BHW-1:0] base_hi;

  assign in_win = addr[ADDR_W-1:WIN_W] == CFG_BASE[ADDR_W-1:WIN_W];
  assign idx_ok = addr[WIN_W-1:2] == '0;
  assign idx    = addr[1:0];
  assign active = chain_in && !cfgd && in_win;
  assign cfg_rd = rd && active;
  assign cfg_wr = wr && !rd && active && idx_ok;

  xcfg_id_regs #(
    .DATA_W(DATA_W), .PRODUCT(PRODUCT), .SIZE_CODE(SIZE_CODE), .IS_IO(IS_IO)
  ) u_id (
    .clk(clk), .rst(rst), .cfg_rd(cfg_rd), .idx_ok(idx_ok), .idx(idx),
    .rdata(rdata), .cfg_hit(cfg_hit)
  );

  xcfg_state #(.BHW(BHW)) u_state (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .idx(idx), .wbase(wdata[BHW-1:0]),
    .cfgd(cfgd), .dec_en(dec_en), .base_hi(base_hi)
  );

  xcfg_decode #(.ADDR_W(ADDR_W), .MIN_LOG2(MIN_LOG2), .SZ_LOG(SZ_LOG)) u_dec (
    .clk(clk), .rst(rst), .dec_en(dec_en), .base_hi(base_hi), .addr(addr),
    .acc(rd | wr), .sel(sel)
  );

  assign chain_out = cfgd;
endmodule

// File: rtl/xcfg_card_chk.sv
module xcfg_card_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              rd,
  input logic              wr,
  input logic              chain_in,
  input logic [DATA_W-1:0] rdata,
  input logic              cfg_hit,
  input logic              sel,
  input logic              chain_out
);
  // R1
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!chain_out && !sel && !cfg_hit && rdata == '0));

  // R3: no read data without a configuration hit
  a_r3_rdata_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !cfg_hit |-> rdata == '0);

  // R4
  a_r4_chain_low_no_hit: assert property (@(posedge clk) disable iff (rst)
    !chain_in |=> !cfg_hit);

  // R4
  a_r4_chain_low_no_cfg: assert property (@(posedge clk) disable iff (rst)
    (!chain_in && !chain_out) |=> !chain_out);

  // R5 / R8: configuration only comes from a write
  a_r5_cfg_from_write: assert property (@(posedge clk) disable iff (rst)
    $rose(chain_out) |-> ($past(wr) && !$past(rd)));

  // R6
  a_r6_silent_after_cfg: assert property (@(posedge clk) disable iff (rst)
    chain_out |-> !cfg_hit);

  // R9
  a_r9_no_sel_unconfigured: assert property (@(posedge clk) disable iff (rst)
    !chain_out |-> !sel);

  // R7: select only follows an access
  a_r7_sel_needs_access: assert property (@(posedge clk) disable iff (rst)
    sel |-> ($past(rd) || $past(wr)));

  // R10
  a_r10_chain_sticky: assert property (@(posedge clk) disable iff (rst)
    chain_out |=> chain_out);
endmodule

bind xcfg_card xcfg_card_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .rd(rd), .wr(wr), .chain_in(chain_in),
  .rdata(rdata), .cfg_hit(cfg_hit), .sel(sel), .chain_out(chain_out)
);

// File: tb/tb_xcfg_card.sv
module tb_xcfg_card;
  localparam int ADDR_W = 24;
  localparam int DATA_W = 8;
  localparam logic [ADDR_W-1:0] WIN = 24'hE80000;
  localparam logic [7:0] PROD = 8'hA7;
  localparam logic [2:0] SZC  = 3'd2;
  localparam int SIZE = 65536 << SZC;

  logic clk = 1'b0, rst = 1'b1, rd = 1'b0, wr = 1'b0, chain_in = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic [DATA_W-1:0] rdata;
  logic cfg_hit, sel, chain_out;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // model state
  bit m_cfgd = 0, m_dec = 0;
  int m_base = 0;

  always #5 clk = ~clk;

  xcfg_card #(.PRODUCT(PROD), .SIZE_CODE(SZC)) dut (
    .clk(clk), .rst(rst), .addr(addr), .rd(rd), .wr(wr), .wdata(wdata),
    .rdata(rdata), .cfg_hit(cfg_hit), .sel(sel), .chain_in(chain_in),
    .chain_out(chain_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit in_win(input logic [23:0] a);
    return a[23:8] == WIN[23:8];
  endfunction

  function automatic logic [7:0] id_val(input logic [23:0] a);
    if (a[7:0] == 8'd0) return PROD;
    if (a[7:0] == 8'd1) return {5'b0, SZC};
    return 8'h00;
  endfunction

  function automatic bit in_rng(input logic [23:0] a);
    return m_dec && int'(a) >= m_base && int'(a) < m_base + SIZE;
  endfunction

  // drive one access at a falling edge, check at the next falling edge
  task automatic access(input logic [23:0] a, input bit r, input bit w,
                        input logic [7:0] d, input string req);
    bit e_hit, e_sel;
    logic [7:0] e_rd;
    addr = a; rd = r; wr = w; wdata = d;
    e_hit = r && chain_in && !m_cfgd && in_win(a);
    e_rd  = e_hit ? id_val(a) : 8'h00;
    e_sel = (r || w) && in_rng(a);
    if (w && !r && chain_in && !m_cfgd && in_win(a)) begin
      if (a[7:0] == 8'd2) begin m_cfgd = 1; m_dec = 1; m_base = int'(d) << 16; end
      else if (a[7:0] == 8'd3) m_cfgd = 1;
    end
    @(negedge clk);
    chk(cfg_hit == e_hit, {req, " cfg_hit"}, cfg_hit, e_hit);
    chk(rdata == e_rd, {req, " rdata"}, rdata, e_rd);
    chk(sel == e_sel, {req, " sel"}, sel, e_sel);
    chk(chain_out == m_cfgd, {req, " chain_out"}, chain_out, m_cfgd);
    rd = 0; wr = 0;
  endtask

  task automatic do_reset();
    rst = 1; rd = 0; wr = 0;
    repeat (3) @(negedge clk);
    // R1
    chk(chain_out == 0 && sel == 0 && cfg_hit == 0 && rdata == 0, "R1 reset outputs",
        {chain_out, sel, cfg_hit, rdata}, 0);
    m_cfgd = 0; m_dec = 0; m_base = 0;
    rst = 0;
  endtask

  function automatic logic [23:0] rnd_addr();
    int k = $urandom_range(0, 3);
    if (k == 0) return WIN | 24'($urandom_range(0, 7));
    return 24'($urandom_range(32'h1F0000, 32'h24FFFF));
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    do_reset();
    // R4: chain low, window ignored
    chain_in = 0;
    access(WIN, 1, 0, 0, "R4 read chain low");
    access(WIN | 24'd2, 0, 1, 8'h20, "R4 base write chain low");
    access(WIN | 24'd3, 0, 1, 0, "R4 shut write chain low");
    // R2, R3
    chain_in = 1;
    access(WIN, 1, 0, 0, "R2 product read");
    access(WIN | 24'd1, 1, 0, 0, "R3 size read");
    access(WIN | 24'd5, 1, 0, 0, "R3 other offset");
    access(WIN | 24'd0, 0, 1, 8'h55, "R3 write to id ignored");
    access(WIN | 24'd1, 0, 1, 8'h55, "R3 write to size ignored");
    access(24'h200000, 1, 0, 0, "R9 region before config");
    for (int i = 0; i < 60; i++) begin
      logic [23:0] a = rnd_addr();
      if (in_win(a) && a[7:0] >= 8'd2) access(a, 1, 0, 0, "R9 random read");
      else access(a, $urandom_range(0, 1) == 1, 0, 0, "R9 random");
    end
    // R5
    access(WIN | 24'd2, 0, 1, 8'h20, "R5 base write");
    // R6
    access(WIN, 1, 0, 0, "R6 window read after cfg");
    access(WIN | 24'd2, 0, 1, 8'h30, "R6 second base write");
    // R7 boundaries
    access(24'h1FFFFF, 1, 0, 0, "R7 base-1");
    access(24'h200000, 0, 1, 8'h11, "R7 base");
    access(24'h23FFFF, 1, 0, 0, "R7 last");
    access(24'h240000, 1, 0, 0, "R7 last+1");
    access(24'h300000, 1, 0, 0, "R6 old region kept");
    for (int i = 0; i < 300; i++) begin
      bit w = $urandom_range(0, 1) == 1;
      access(rnd_addr(), !w, w, 8'($urandom), "R7 random R10");
    end
    // R8 after a fresh reset
    do_reset();
    chain_in = 1;
    access(WIN | 24'd3, 0, 1, 8'h20, "R8 shut-up write");
    access(24'h200000, 1, 0, 0, "R8 no decode");
    for (int i = 0; i < 150; i++) begin
      bit w = $urandom_range(0, 1) == 1;
      access(rnd_addr(), !w, w, 8'($urandom), "R8 random R10");
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule